// File: doc/BRIEF.md
# Clock output stop and power-down gate

This block sits between the internally generated clocks of a multi-output clock generator and its output pins. Each output lane is a clock gate. The gate turns an output off or back on only while that output's own source clock is LOW. As a result, a lane never emits a high pulse shorter than its source's high time. Lanes are grouped by source clock:

- CPU: one stoppable output and a set of free-running outputs.
- SDRAM: a set of outputs plus one free-running memory-hub clock.
- PCI: a set of stoppable outputs plus one free-running output.
- Fixed 66 MHz: a set of outputs.
- Interrupt-controller: a set of outputs.
- Reference: one output.
- 48 MHz: two outputs, one for USB and one for a video dot clock.

Per-output enable bits come from a configuration register bank. Two active-low stop pins halt some of the outputs: one acts on the stoppable CPU output and one on the stoppable PCI outputs. The free-running outputs ignore both stop pins.

An active-low asynchronous power-down pin is sampled on CPU clock rising edges. After two consecutive LOW samples, every output is parked LOW from the next CPU falling edge onward. A PLL-off request is then raised in the reference domain. After reset, and again after power-down is released, the PLL-off request drops. All outputs then stay LOW for `SETTLE_CYC` reference cycles, which models PLL settling, before they restart cleanly.

Top module: `clk_out_gate`

## Requirements
- R1: While `rst_ni` is LOW, every clock output and `pll_off_o` are LOW.
- R2: After `rst_ni` rises, no output produces a rising edge for at least `SETTLE_CYC`-1 reference clock periods. After that, every enabled, unstopped output toggles.
- R3: While `cpu_stp_ni` is LOW, `cpu0_o` stays LOW. It stops after two CPU rising-edge samples of the pin and parks at the following falling edge.
- R4: While `pci_stp_ni` is LOW, all `pci_o` bits stay LOW after two PCI rising-edge samples and the following falling edge.
- R5: `cpu_f_o`, `dclk_o`, `pci_f_o`, `apic_o` and `ref_o` keep toggling whatever the level of either stop pin.
- R6: An output whose enable bit is 0 (`en_cpu0_i`, `en_cpuf_i[i]`, `en_sdram_i[i]`, `en_pci_i[i]`, `en_m66_i[i]`, `en_usb_i`, `en_dot_i`) stays LOW. Setting the bit to 1 lets the output run.
- R7: Every high pulse on any output lasts exactly the high time of its source clock, including the pulses around stop, enable and power-down changes.
- R8: Once `pwr_dn_ni` is driven LOW just after a CPU rising edge, `cpu0_o` and `cpu_f_o` give exactly two more rising edges and then stay LOW.
- R9: After power-down has been taken, every output stays LOW and `pll_off_o` is HIGH while `pwr_dn_ni` remains LOW.
- R10: After `pwr_dn_ni` returns HIGH, `pll_off_o` falls within a few reference cycles. The outputs stay LOW for `SETTLE_CYC` further reference cycles and then resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_clk_i | input | 1 | Internal CPU clock |
| sdram_clk_i | input | 1 | Internal SDRAM clock |
| pci_clk_i | input | 1 | Internal PCI clock |
| m66_clk_i | input | 1 | Internal fixed 66 MHz clock |
| apic_clk_i | input | 1 | Internal interrupt-controller clock |
| ref_clk_i | input | 1 | Crystal reference clock |
| f48_clk_i | input | 1 | Internal 48 MHz clock |
| pwr_dn_ni | input | 1 | Asynchronous power-down request, active LOW |
| cpu_stp_ni | input | 1 | Stop for `cpu0_o`, active LOW |
| pci_stp_ni | input | 1 | Stop for `pci_o`, active LOW |
| en_cpu0_i | input | 1 | Enable for `cpu0_o` |
| en_cpuf_i | input | N_CPUF | Enables for `cpu_f_o` |
| en_sdram_i | input | N_SDRAM | Enables for `sdram_o` |
| en_pci_i | input | N_PCI | Enables for `pci_o` |
| en_m66_i | input | N_M66 | Enables for `m66_o` |
| en_usb_i | input | 1 | Enable for `usb_o` |
| en_dot_i | input | 1 | Enable for `dot_o` |
| cpu0_o | output | 1 | Stoppable CPU clock |
| cpu_f_o | output | N_CPUF | Free-running CPU clocks |
| sdram_o | output | N_SDRAM | SDRAM clocks |
| dclk_o | output | 1 | Free-running memory-hub clock |
| pci_o | output | N_PCI | Stoppable PCI clocks |
| pci_f_o | output | 1 | Free-running PCI clock |
| m66_o | output | N_M66 | Fixed 66 MHz clocks |
| apic_o | output | N_APIC | Interrupt-controller clocks |
| ref_o | output | 1 | Buffered reference clock |
| usb_o | output | 1 | 48 MHz USB clock |
| dot_o | output | 1 | 48 MHz dot clock |
| pll_off_o | output | 1 | PLL shut-off request |

## Verification
A lane enable flop that is stuck or updated on the wrong edge shows at the port within one source period. It appears as a missing rising edge, an extra one, or a high pulse shorter than the source high time; a pulse-width monitor on every output catches the last case. A power-down synchronizer of the wrong depth changes the count of CPU rising edges seen after the pin falls, which is exactly two on a correct design. A settle counter that is wrong, or a PLL-off flag that fails to clear, shows within a few reference periods of reset or power-down exit. It appears as outputs that start too early, never restart, or do not match `pll_off_o`.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter int unsigned SYNC = clk_gate_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  logic [SYNC-1:0] sync_q;
  logic            en_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-2:0], run_i};

  // enable moves only while clk_i is low: no runt pulse
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= sync_q[SYNC-1];

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int unsigned LANES = 1,
  parameter int unsigned SYNC  = clk_gate_pkg::SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] run_i,
  output logic [LANES-1:0] clk_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    clk_gate_cell #(.SYNC(SYNC)) i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i[l]),
      .clk_o  (clk_o[l])
    );
  end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned SYNC       = clk_gate_pkg::SYNC_DEPTH
) (
  input  logic cpu_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic pwr_dn_ni,
  output logic pd_cpu_o,
  output logic pll_off_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = clk_gate_pkg::cnt_width(SETTLE_CYC);

  logic [SYNC-1:0]  pw_cpu_q, pd_ref_q, pw_ref_q;
  logic             pd_q, off_q;
  logic [CNT_W-1:0] settle_q;

  // entry: two low samples on CPU rising edges, taken at next falling edge
  always_ff @(posedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) pw_cpu_q <= '1;
    else         pw_cpu_q <= {pw_cpu_q[SYNC-2:0], pwr_dn_ni};

  always_ff @(negedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) pd_q <= 1'b0;
    else         pd_q <= ~pw_cpu_q[SYNC-1];

  // reference domain keeps running while the PLL is off
  always_ff @(posedge ref_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pd_ref_q <= '0;
      pw_ref_q <= '1;
    end else begin
      pd_ref_q <= {pd_ref_q[SYNC-2:0], pd_q};
      pw_ref_q <= {pw_ref_q[SYNC-2:0], pwr_dn_ni};
    end

  always_ff @(posedge ref_clk_i or negedge rst_ni)
    if (!rst_ni)                   off_q <= 1'b0;
    else if (pw_ref_q[SYNC-1])     off_q <= 1'b0;
    else if (pd_ref_q[SYNC-1])     off_q <= 1'b1;

  always_ff @(posedge ref_clk_i or negedge rst_ni)
    if (!rst_ni)                 settle_q <= CNT_W'(SETTLE_CYC);
    else if (off_q)              settle_q <= CNT_W'(SETTLE_CYC);
    else if (settle_q != '0)     settle_q <= settle_q - 1'b1;

  assign pd_cpu_o  = pd_q;
  assign pll_off_o = off_q;
  assign ready_o   = (settle_q == '0) && !off_q;
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int unsigned N_CPUF     = 2,
  parameter int unsigned N_SDRAM    = 6,
  parameter int unsigned N_PCI      = 6,
  parameter int unsigned N_M66      = 3,
  parameter int unsigned N_APIC     = 2,
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned SYNC       = clk_gate_pkg::SYNC_DEPTH
) (
  input  logic               rst_ni,
  input  logic               cpu_clk_i,
  input  logic               sdram_clk_i,
  input  logic               pci_clk_i,
  input  logic               m66_clk_i,
  input  logic               apic_clk_i,
  input  logic               ref_clk_i,
  input  logic               f48_clk_i,
  input  logic               pwr_dn_ni,
  input  logic               cpu_stp_ni,
  input  logic               pci_stp_ni,
  input  logic               en_cpu0_i,
  input  logic [N_CPUF-1:0]  en_cpuf_i,
  input  logic [N_SDRAM-1:0] en_sdram_i,
  input  logic [N_PCI-1:0]   en_pci_i,
  input  logic [N_M66-1:0]   en_m66_i,
  input  logic               en_usb_i,
  input  logic               en_dot_i,
  output logic               cpu0_o,
  output logic [N_CPUF-1:0]  cpu_f_o,
  output logic [N_SDRAM-1:0] sdram_o,
  output logic               dclk_o,
  output logic [N_PCI-1:0]   pci_o,
  output logic               pci_f_o,
  output logic [N_M66-1:0]   m66_o,
  output logic [N_APIC-1:0]  apic_o,
  output logic               ref_o,
  output logic               usb_o,
  output logic               dot_o,
  output logic               pll_off_o
);
  localparam int unsigned L_CPU = N_CPUF + 1;
  localparam int unsigned L_SDR = N_SDRAM + 1;
  localparam int unsigned L_PCI = N_PCI + 1;

  logic pd_cpu, ready, run_all, run_cpu;

  pwr_seq #(.SETTLE_CYC(SETTLE_CYC), .SYNC(SYNC)) i_pwr_seq (
    .cpu_clk_i (cpu_clk_i),
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .pwr_dn_ni (pwr_dn_ni),
    .pd_cpu_o  (pd_cpu),
    .pll_off_o (pll_off_o),
    .ready_o   (ready)
  );

  // CPU lanes sample the raw pin so entry timing counts their own edges
  assign run_cpu = pwr_dn_ni & ready;
  assign run_all = ~pd_cpu & ready;

  logic [L_CPU-1:0] cpu_run, cpu_clk;
  logic [L_SDR-1:0] sdr_run, sdr_clk;
  logic [L_PCI-1:0] pci_run, pci_clk;
  logic [1:0]       f48_run, f48_clk;

  assign cpu_run = {en_cpuf_i & {N_CPUF{run_cpu}}, en_cpu0_i & cpu_stp_ni & run_cpu};
  assign sdr_run = {1'b1, en_sdram_i} & {L_SDR{run_all}};
  assign pci_run = {1'b1, en_pci_i & {N_PCI{pci_stp_ni}}} & {L_PCI{run_all}};
  assign f48_run = {en_dot_i, en_usb_i} & {2{run_all}};

  clk_gate_bank #(.LANES(L_CPU), .SYNC(SYNC)) i_cpu (
    .clk_i (cpu_clk_i), .rst_ni (rst_ni), .run_i (cpu_run), .clk_o (cpu_clk));
  clk_gate_bank #(.LANES(L_SDR), .SYNC(SYNC)) i_sdr (
    .clk_i (sdram_clk_i), .rst_ni (rst_ni), .run_i (sdr_run), .clk_o (sdr_clk));
  clk_gate_bank #(.LANES(L_PCI), .SYNC(SYNC)) i_pci (
    .clk_i (pci_clk_i), .rst_ni (rst_ni), .run_i (pci_run), .clk_o (pci_clk));
  clk_gate_bank #(.LANES(N_M66), .SYNC(SYNC)) i_m66 (
    .clk_i (m66_clk_i), .rst_ni (rst_ni), .run_i (en_m66_i & {N_M66{run_all}}), .clk_o (m66_o));
  clk_gate_bank #(.LANES(N_APIC), .SYNC(SYNC)) i_apic (
    .clk_i (apic_clk_i), .rst_ni (rst_ni), .run_i ({N_APIC{run_all}}), .clk_o (apic_o));
  clk_gate_bank #(.LANES(1), .SYNC(SYNC)) i_ref (
    .clk_i (ref_clk_i), .rst_ni (rst_ni), .run_i (run_all), .clk_o (ref_o));
  clk_gate_bank #(.LANES(2), .SYNC(SYNC)) i_f48 (
    .clk_i (f48_clk_i), .rst_ni (rst_ni), .run_i (f48_run), .clk_o (f48_clk));

  assign cpu0_o  = cpu_clk[0];
  assign cpu_f_o = cpu_clk[L_CPU-1:1];
  assign sdram_o = sdr_clk[N_SDRAM-1:0];
  assign dclk_o  = sdr_clk[N_SDRAM];
  assign pci_o   = pci_clk[N_PCI-1:0];
  assign pci_f_o = pci_clk[N_PCI];
  assign usb_o   = f48_clk[0];
  assign dot_o   = f48_clk[1];
endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk #(
  parameter int unsigned N_CPUF  = 2,
  parameter int unsigned N_SDRAM = 6,
  parameter int unsigned N_PCI   = 6,
  parameter int unsigned N_M66   = 3,
  parameter int unsigned N_APIC  = 2
) (
  input logic               rst_ni,
  input logic               cpu_clk_i,
  input logic               pci_clk_i,
  input logic               ref_clk_i,
  input logic               pwr_dn_ni,
  input logic               cpu_stp_ni,
  input logic               pci_stp_ni,
  input logic               cpu0_o,
  input logic [N_CPUF-1:0]  cpu_f_o,
  input logic [N_SDRAM-1:0] sdram_o,
  input logic               dclk_o,
  input logic [N_PCI-1:0]   pci_o,
  input logic               pci_f_o,
  input logic [N_M66-1:0]   m66_o,
  input logic [N_APIC-1:0]  apic_o,
  input logic               ref_o,
  input logic               usb_o,
  input logic               dot_o,
  input logic               pll_off_o
);
  logic [1:0] pw_h, cs_h, ps_h;
  logic       all_low;

  always_ff @(posedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) begin pw_h <= 2'b11; cs_h <= 2'b11; end
    else begin pw_h <= {pw_h[0], pwr_dn_ni}; cs_h <= {cs_h[0], cpu_stp_ni}; end

  always_ff @(posedge pci_clk_i or negedge rst_ni)
    if (!rst_ni) ps_h <= 2'b11;
    else         ps_h <= {ps_h[0], pci_stp_ni};

  assign all_low = !cpu0_o && cpu_f_o == '0 && sdram_o == '0 && !dclk_o &&
                   pci_o == '0 && !pci_f_o && m66_o == '0 && apic_o == '0 &&
                   !ref_o && !usb_o && !dot_o;

  always_comb
    if (!rst_ni) a_r1_reset_low: assert (all_low && !pll_off_o);

  a_r3_cpu_stop_parks: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cs_h == 2'b00) |=> !cpu0_o);

  a_r4_pci_stop_parks: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    (ps_h == 2'b00) |=> (pci_o == '0));

  a_r8_pd_two_samples: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (pw_h == 2'b00) |=> (!cpu0_o && cpu_f_o == '0));

  a_r9_pll_off_all_low: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    pll_off_o |-> all_low);
endmodule

bind clk_out_gate clk_out_gate_chk #(
  .N_CPUF(N_CPUF), .N_SDRAM(N_SDRAM), .N_PCI(N_PCI), .N_M66(N_M66), .N_APIC(N_APIC)
) i_chk (
  .rst_ni     (rst_ni),
  .cpu_clk_i  (cpu_clk_i),
  .pci_clk_i  (pci_clk_i),
  .ref_clk_i  (ref_clk_i),
  .pwr_dn_ni  (pwr_dn_ni),
  .cpu_stp_ni (cpu_stp_ni),
  .pci_stp_ni (pci_stp_ni),
  .cpu0_o     (cpu0_o),
  .cpu_f_o    (cpu_f_o),
  .sdram_o    (sdram_o),
  .dclk_o     (dclk_o),
  .pci_o      (pci_o),
  .pci_f_o    (pci_f_o),
  .m66_o      (m66_o),
  .apic_o     (apic_o),
  .ref_o      (ref_o),
  .usb_o      (usb_o),
  .dot_o      (dot_o),
  .pll_off_o  (pll_off_o)
);

// File: tb/test_clk_out_gate.sv
`timescale 1ns/1ps
module test_clk_out_gate;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;
  localparam int REF_P      = 70;
  localparam int NB         = 25;
  localparam int NV         = 6;
  // fields: [21] cpu stop_n, [20] pci stop_n, [19:18] en_cpuf, [17] en_cpu0,
  // [16:11] en_sdram, [10:5] en_pci, [4:2] en_m66, [1] en_usb, [0] en_dot
  localparam logic [21:0] VEC [NV] = '{
    22'h3FFFFF, 22'h1FFFFF, 22'h2FFFFF, 22'h0FFFFF,
    {2'b11, 3'b010, 6'b101010, 6'b010101, 3'b101, 1'b0, 1'b1},
    {2'b11, 20'b0}
  };

  logic rst_n = 1'b0;
  logic cpu_clk = 0, sdr_clk = 0, pci_clk = 0, m66_clk = 0, apic_clk = 0, ref_clk = 0, f48_clk = 0;
  logic pwr_n = 1'b1, cstp_n = 1'b1, pstp_n = 1'b1;
  logic en_c0, en_usb, en_dot;
  logic [1:0] en_cf;
  logic [5:0] en_sd, en_pc;
  logic [2:0] en_m;
  logic cpu0, dclk, pcif, refo, usb, dot, pll_off;
  logic [1:0] cpuf, apic;
  logic [5:0] sdram, pci;
  logic [2:0] m66;
  logic [NB-1:0] outs;

  int total = 0, bad = 0, bad_pulse = 0;
  bit mon_on = 0;
  int rise_cnt [NB];
  realtime rise_t [NB];

  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
  initial begin #2; forever #5 sdr_clk = ~sdr_clk; end
  always #15 pci_clk  = ~pci_clk;
  always #8  m66_clk  = ~m66_clk;
  always #15 apic_clk = ~apic_clk;
  always #(REF_P/2) ref_clk = ~ref_clk;
  always #10 f48_clk  = ~f48_clk;

  clk_out_gate i_clk_out_gate (
    .rst_ni(rst_n), .cpu_clk_i(cpu_clk), .sdram_clk_i(sdr_clk), .pci_clk_i(pci_clk),
    .m66_clk_i(m66_clk), .apic_clk_i(apic_clk), .ref_clk_i(ref_clk), .f48_clk_i(f48_clk),
    .pwr_dn_ni(pwr_n), .cpu_stp_ni(cstp_n), .pci_stp_ni(pstp_n),
    .en_cpu0_i(en_c0), .en_cpuf_i(en_cf), .en_sdram_i(en_sd), .en_pci_i(en_pc),
    .en_m66_i(en_m), .en_usb_i(en_usb), .en_dot_i(en_dot),
    .cpu0_o(cpu0), .cpu_f_o(cpuf), .sdram_o(sdram), .dclk_o(dclk), .pci_o(pci),
    .pci_f_o(pcif), .m66_o(m66), .apic_o(apic), .ref_o(refo), .usb_o(usb),
    .dot_o(dot), .pll_off_o(pll_off));

  assign outs = {dot, usb, refo, apic, m66, pcif, pci, dclk, sdram, cpuf, cpu0};

  function automatic realtime half_of(input int b);
    if (b <= 9)  return 5.0;
    if (b <= 16) return 15.0;
    if (b <= 19) return 8.0;
    if (b <= 21) return 15.0;
    if (b == 22) return 35.0;
    return 10.0;
  endfunction

  for (genvar g = 0; g < NB; g++) begin : g_mon
    always @(posedge outs[g]) begin
      rise_cnt[g] = rise_cnt[g] + 1;
      rise_t[g]   = $realtime;
    end
    always @(negedge outs[g])
      if (mon_on && (($realtime - rise_t[g]) > half_of(g) + 0.01 ||
                     ($realtime - rise_t[g]) < half_of(g) - 0.01))
        bad_pulse = bad_pulse + 1;
  end

  function automatic bit expect_on(input int b, input logic [21:0] v);
    if (b == 0)  return v[17] & v[21];
    if (b <= 2)  return v[17+b];
    if (b <= 8)  return v[11+b-3];
    if (b == 9)  return 1'b1;
    if (b <= 15) return v[5+b-10] & v[20];
    if (b == 16) return 1'b1;
    if (b <= 19) return v[2+b-17];
    if (b <= 22) return 1'b1;
    if (b == 23) return v[1];
    return v[0];
  endfunction

  function automatic string req_of(input int b);
    if (b == 0) return "R3";
    if (b >= 10 && b <= 15) return "R4";
    if (b == 1 || b == 2 || b == 9 || b >= 16 && b <= 22 && !(b >= 17 && b <= 19)) return "R5";
    return "R6";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_cnt();
    for (int i = 0; i < NB; i++) rise_cnt[i] = 0;
  endtask

  task automatic apply(input logic [21:0] v);
    cstp_n = v[21]; pstp_n = v[20]; en_cf = v[19:18]; en_c0 = v[17];
    en_sd = v[16:11]; en_pc = v[10:5]; en_m = v[4:2]; en_usb = v[1]; en_dot = v[0];
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #50000;
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int sum;
    apply(VEC[0]);
    #101;
    // R1: reset holds everything low
    check(outs == '0, "R1", int'(outs), 0);
    check(pll_off == 1'b0, "R1", int'(pll_off), 0);
    #50 rst_n = 1'b1;
    clear_cnt(); mon_on = 1;
    // R2: quiet for the settle window after reset
    #((SETTLE-1)*REF_P);
    sum = 0;
    for (int i = 0; i < NB; i++) sum += rise_cnt[i];
    check(sum == 0, "R2", sum, 0);
    #1500;
    clear_cnt(); #400;
    check(rise_cnt[0] >= 2 && rise_cnt[24] >= 2, "R2", rise_cnt[0], 2);

    // R3..R6: vector table walk
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v]);
      #201; clear_cnt(); #400;
      for (int b = 0; b < NB; b++)
        if (expect_on(b, VEC[v])) check(rise_cnt[b] >= 2, req_of(b), rise_cnt[b], 2);
        else                      check(rise_cnt[b] == 0, req_of(b), rise_cnt[b], 0);
    end

    // R8: exactly two CPU rising edges after the pin falls
    apply(VEC[0]); #301;
    @(posedge cpu_clk); #1;
    pwr_n = 1'b0; clear_cnt();
    #100;
    check(rise_cnt[0] == 2, "R8", rise_cnt[0], 2);
    check(rise_cnt[1] == 2, "R8", rise_cnt[1], 2);
    // R9: all parked, PLL off
    #400;
    check(pll_off == 1'b1, "R9", int'(pll_off), 1);
    clear_cnt(); #300;
    sum = 0;
    for (int i = 0; i < NB; i++) sum += rise_cnt[i];
    check(sum == 0, "R9", sum, 0);
    check(pll_off == 1'b1, "R9", int'(pll_off), 1);

    // R10: exit, settle, resume
    pwr_n = 1'b1; clear_cnt();
    #300;
    check(pll_off == 1'b0, "R10", int'(pll_off), 0);
    sum = 0;
    for (int i = 0; i < NB; i++) sum += rise_cnt[i];
    check(sum == 0, "R10", sum, 0);
    #1500; clear_cnt(); #400;
    check(rise_cnt[0] >= 2, "R10", rise_cnt[0], 2);
    check(rise_cnt[22] >= 2, "R10", rise_cnt[22], 2);

    // R7: no shortened pulse anywhere in the run
    check(bad_pulse == 0, "R7", bad_pulse, 0);
    finish_run();
  end
endmodule